// File: doc/BRIEF.md
# Segment Descriptor Shadow Cache Loader

This block holds a hidden copy of the segment descriptor for each of four segment registers and for the local-table register. Each copy is 48 bits: a 16-bit limit, a 24-bit base and an 8-bit access-rights byte. When a selector is written to one of the five targets, a small state machine computes the descriptor address and fetches the descriptor with three 16-bit reads. It checks the access-rights byte. If the check passes, it installs the fields. If the check fails, it raises a fault and leaves the copy as it was. Address translation then reads the installed fields through a select port, with no further memory traffic until the same selector is written again.

A selector is a 13-bit index in bits 15..3, a table-select flag in bit 2 and a requested privilege level in bits 1..0. The index is scaled by eight and added to a table base. The table base is either the global-table base input or the base held in the local-table entry. A selector written to the local-table register always indexes the global table. That entry then becomes the base of the current local table for later lookups. Target codes 5 to 7 are not valid, and a write that names them is dropped.

Top module: `seg_shadow_loader`

## Requirements
- R1: After reset, all five entries read zero in limit, base and rights, `selWrReady` is 1 and `busy` is 0.
- R2: A write is accepted on a clock edge where `selWrValid` and `selWrReady` are both 1. From the next cycle until the completion state, `busy` is 1 and `selWrReady` is 0, so further writes are held off. Memory requests appear only while `busy` is 1.
- R3: The descriptor address is the table base plus selector bits 15..3 times 8. The table base is `globalBase` when selector bit 2 is 0, and the local-table entry's base when bit 2 is 1. Three reads follow at the descriptor address +0, +2 and +4. Word 0 is the limit and word 1 is base bits 15..0. Word 2 carries base bits 23..16 in its low byte and the rights byte in its high byte.
- R4: For target 4 (local table), the global table is used whatever the value of selector bit 2. Targets are 0 code, 1 data, 2 stack, 3 extra data, 4 local table.
- R5: On success, `loadDone` pulses for one cycle. From the next cycle, the target entry shows the fetched limit, base and rights.
- R6: A rights byte with bit 7 (present) equal to 0 causes a one-cycle `loadFault` pulse and no change to the entry.
- R7: For targets 1 and 3, a requested level (selector bits 1..0) numerically greater than the descriptor level (rights bits 6..5) causes a fault.
- R8: For target 2, the privilege rule of R7 applies. The load also faults unless rights bit 4 is 1, bit 3 is 0 and bit 1 is 1, which marks a writable data segment.
- R9: A successful load whose rights bit 4 is 1 and bit 0 (accessed) is 0 issues one 16-bit write to descriptor address +4. The written word has the rights byte with bit 0 set in the high byte and base bits 23..16 in the low byte. The cached rights also show bit 0 set. Any other load issues no write.
- R10: An entry changes only when a load completes. Changing the descriptor in memory without a selector write has no effect on the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selWrValid | input | 1 | Selector write request |
| selWrReady | output | 1 | Block can accept a selector write |
| selWrTarget | input | 3 | Target entry code (0..4) |
| selWrValue | input | 16 | Selector value |
| globalBase | input | 24 | Base address of the global descriptor table |
| memReqValid | output | 1 | Memory request, held until response |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 24 | Byte address of the 16-bit word |
| memReqWdata | output | 16 | Write data |
| memRspValid | input | 1 | Response or write acknowledge, one cycle |
| memRspData | input | 16 | Read data |
| busy | output | 1 | Load in progress |
| loadDone | output | 1 | One-cycle pulse on successful install |
| loadFault | output | 1 | One-cycle pulse on failed check |
| shadowSel | input | 3 | Entry to show on the field outputs |
| shadowBase | output | 24 | Cached base of the selected entry |
| shadowLimit | output | 16 | Cached limit of the selected entry |
| shadowRights | output | 8 | Cached rights byte of the selected entry |

## Verification
The load path is driven with selectors whose table-select bit picks the global table, picks the local table, or is overridden by the local-table target. A wrong table base shows up as fields fetched from the wrong slot. Rights bytes are chosen so that each check is the only one that can fire: a missing present bit, a requested level above or below the descriptor level, a read-only data segment on the stack target, and a code segment on the stack target. Cleared and already-set accessed bits separate loads that write back from loads that do not. A final case edits a descriptor in memory without a selector write, then writes the selector, to show the entry follows only the write.

// File: rtl/seg_shadow_pkg.sv
package seg_shadow_pkg;
  localparam int SEL_W    = 16;
  localparam int WORD_W   = 16;
  localparam int BASE_W   = 24;
  localparam int LIMIT_W  = 16;
  localparam int RIGHTS_W = 8;
  localparam int ADDR_W   = 24;
  localparam int RPL_W    = 2;
  localparam int OFF_W    = 2;

  // rights byte bit positions (decoded by the checker stage)
  localparam int RB_PRESENT = 7;
  localparam int RB_DPL_HI  = 6;
  localparam int RB_DPL_LO  = 5;
  localparam int RB_SEG     = 4;
  localparam int RB_EXEC    = 3;
  localparam int RB_WRITE   = 1;
  localparam int RB_ACC     = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_CHECK, ST_MARK, ST_UPDATE, ST_FAULT
  } loadState_e;

  typedef struct packed {
    logic             capSel;
    logic             capW0;
    logic             capW1;
    logic             capW2;
    logic             setAcc;
    logic             commit;
    logic [OFF_W-1:0] wordOff;
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_shadow_ctrl.sv
module seg_shadow_ctrl
  import seg_shadow_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int STACK_IDX = 2,
  parameter logic [NUM_SEG-1:0] DATA_MASK = 4'b1010,
  localparam int TGT_W = $clog2(NUM_SEG + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selWrValid,
  input  logic [TGT_W-1:0]    selWrTarget,
  input  logic                memRspValid,
  input  logic [TGT_W-1:0]    curTarget,
  input  logic [RPL_W-1:0]    curRpl,
  input  logic [RIGHTS_W-1:0] curRights,
  output ctrlStrobes_t        strobes,
  output logic                selWrReady,
  output logic                busy,
  output logic                memReqValid,
  output logic                memReqWrite,
  output logic                loadDone,
  output logic                loadFault
);
  loadState_e state, stateNext;

  logic targetOk, dataTgt, stackTgt, privFail, stackFail, checkFail, needMark;

  assign targetOk = selWrTarget <= TGT_W'(NUM_SEG);

  always_comb begin
    dataTgt = 1'b0;
    for (int i = 0; i < NUM_SEG; i++)
      if (curTarget == TGT_W'(i) && DATA_MASK[i]) dataTgt = 1'b1;
  end

  assign stackTgt  = curTarget == TGT_W'(STACK_IDX);
  assign privFail  = (dataTgt || stackTgt) &&
                     (curRpl > curRights[RB_DPL_HI:RB_DPL_LO]);
  assign stackFail = stackTgt && !(curRights[RB_SEG] && !curRights[RB_EXEC] &&
                                   curRights[RB_WRITE]);
  assign checkFail = !curRights[RB_PRESENT] || privFail || stackFail;
  assign needMark  = curRights[RB_SEG] && !curRights[RB_ACC];

  always_comb begin
    stateNext   = state;
    strobes     = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      ST_IDLE: if (selWrValid && targetOk) begin
        strobes.capSel = 1'b1;
        stateNext      = ST_RD0;
      end
      ST_RD0: begin
        memReqValid     = 1'b1;
        strobes.wordOff = 2'd0;
        strobes.capW0   = memRspValid;
        if (memRspValid) stateNext = ST_RD1;
      end
      ST_RD1: begin
        memReqValid     = 1'b1;
        strobes.wordOff = 2'd1;
        strobes.capW1   = memRspValid;
        if (memRspValid) stateNext = ST_RD2;
      end
      ST_RD2: begin
        memReqValid     = 1'b1;
        strobes.wordOff = 2'd2;
        strobes.capW2   = memRspValid;
        if (memRspValid) stateNext = ST_CHECK;
      end
      ST_CHECK: stateNext = checkFail ? ST_FAULT : (needMark ? ST_MARK : ST_UPDATE);
      ST_MARK: begin
        memReqValid     = 1'b1;
        memReqWrite     = 1'b1;
        strobes.wordOff = 2'd2;
        strobes.setAcc  = memRspValid;
        if (memRspValid) stateNext = ST_UPDATE;
      end
      ST_UPDATE: begin
        strobes.commit = 1'b1;
        stateNext      = ST_IDLE;
      end
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign selWrReady = state == ST_IDLE;
  assign busy       = !(state inside {ST_IDLE, ST_UPDATE, ST_FAULT});
  assign loadDone   = state == ST_UPDATE;
  assign loadFault  = state == ST_FAULT;
endmodule

// File: rtl/seg_shadow_dpath.sv
module seg_shadow_dpath
  import seg_shadow_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int TGT_W = $clog2(NUM_SEG + 1),
  localparam int NUM_ENT = NUM_SEG + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [TGT_W-1:0]    selWrTarget,
  input  logic [SEL_W-1:0]    selWrValue,
  input  logic [ADDR_W-1:0]   globalBase,
  input  logic [WORD_W-1:0]   memRspData,
  input  logic [TGT_W-1:0]    shadowSel,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [WORD_W-1:0]   memReqWdata,
  output logic [TGT_W-1:0]    curTarget,
  output logic [RPL_W-1:0]    curRpl,
  output logic [RIGHTS_W-1:0] curRights,
  output logic [BASE_W-1:0]   shadowBase,
  output logic [LIMIT_W-1:0]  shadowLimit,
  output logic [RIGHTS_W-1:0] shadowRights
);
  localparam int LDT_IDX = NUM_SEG;

  logic [SEL_W-1:0]  selReg;
  logic [TGT_W-1:0]  tgtReg;
  logic [WORD_W-1:0] w0, w1, w2;
  logic [BASE_W-1:0]   baseArr   [NUM_ENT];
  logic [LIMIT_W-1:0]  limitArr  [NUM_ENT];
  logic [RIGHTS_W-1:0] rightsArr [NUM_ENT];
  logic [ADDR_W-1:0] tableBase, descAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      tgtReg <= '0;
      w0 <= '0;
      w1 <= '0;
      w2 <= '0;
    end else begin
      if (strobes.capSel) begin
        selReg <= selWrValue;
        tgtReg <= selWrTarget;
      end
      if (strobes.capW0)  w0 <= memRspData;
      if (strobes.capW1)  w1 <= memRspData;
      if (strobes.capW2)  w2 <= memRspData;
      if (strobes.setAcc) w2[WORD_W-RIGHTS_W+RB_ACC] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseArr[g]   <= '0;
        limitArr[g]  <= '0;
        rightsArr[g] <= '0;
      end else if (strobes.commit && tgtReg == TGT_W'(g)) begin
        limitArr[g]  <= w0;
        baseArr[g]   <= {w2[BASE_W-WORD_W-1:0], w1};
        rightsArr[g] <= w2[WORD_W-1:WORD_W-RIGHTS_W];
      end
    end
  end

  // local-table target and flag-clear selectors use the global table
  assign tableBase = (tgtReg == TGT_W'(LDT_IDX) || !selReg[2]) ?
                     globalBase : ADDR_W'(baseArr[LDT_IDX]);
  assign descAddr    = tableBase + ADDR_W'({selReg[SEL_W-1:3], 3'b000});
  assign memReqAddr  = descAddr + ADDR_W'({strobes.wordOff, 1'b0});
  assign memReqWdata = {w2[WORD_W-1:WORD_W-RIGHTS_W] | RIGHTS_W'(1), w2[WORD_W-RIGHTS_W-1:0]};
  assign curRights   = w2[WORD_W-1:WORD_W-RIGHTS_W];
  assign curRpl      = selReg[RPL_W-1:0];
  assign curTarget   = tgtReg;

  always_comb begin
    shadowBase   = '0;
    shadowLimit  = '0;
    shadowRights = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (shadowSel == TGT_W'(i)) begin
        shadowBase   = baseArr[i];
        shadowLimit  = limitArr[i];
        shadowRights = rightsArr[i];
      end
  end
endmodule

// File: rtl/seg_shadow_loader.sv
module seg_shadow_loader
  import seg_shadow_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int STACK_IDX = 2,
  parameter logic [NUM_SEG-1:0] DATA_MASK = 4'b1010,
  localparam int TGT_W = $clog2(NUM_SEG + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selWrValid,
  output logic                selWrReady,
  input  logic [TGT_W-1:0]    selWrTarget,
  input  logic [SEL_W-1:0]    selWrValue,
  input  logic [ADDR_W-1:0]   globalBase,
  output logic                memReqValid,
  output logic                memReqWrite,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [WORD_W-1:0]   memReqWdata,
  input  logic                memRspValid,
  input  logic [WORD_W-1:0]   memRspData,
  output logic                busy,
  output logic                loadDone,
  output logic                loadFault,
  input  logic [TGT_W-1:0]    shadowSel,
  output logic [BASE_W-1:0]   shadowBase,
  output logic [LIMIT_W-1:0]  shadowLimit,
  output logic [RIGHTS_W-1:0] shadowRights
);
  ctrlStrobes_t        strobes;
  logic [TGT_W-1:0]    curTarget;
  logic [RPL_W-1:0]    curRpl;
  logic [RIGHTS_W-1:0] curRights;

  seg_shadow_ctrl #(
    .NUM_SEG(NUM_SEG), .STACK_IDX(STACK_IDX), .DATA_MASK(DATA_MASK)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .selWrValid(selWrValid), .selWrTarget(selWrTarget),
    .memRspValid(memRspValid), .curTarget(curTarget), .curRpl(curRpl),
    .curRights(curRights), .strobes(strobes), .selWrReady(selWrReady),
    .busy(busy), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .loadDone(loadDone), .loadFault(loadFault)
  );

  seg_shadow_dpath #(.NUM_SEG(NUM_SEG)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selWrTarget(selWrTarget),
    .selWrValue(selWrValue), .globalBase(globalBase), .memRspData(memRspData),
    .shadowSel(shadowSel), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .curTarget(curTarget), .curRpl(curRpl), .curRights(curRights),
    .shadowBase(shadowBase), .shadowLimit(shadowLimit), .shadowRights(shadowRights)
  );
endmodule

// File: rtl/seg_shadow_chk.sv
module seg_shadow_chk
  import seg_shadow_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int TGT_W = $clog2(NUM_SEG + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                selWrValid,
  input logic                selWrReady,
  input logic [TGT_W-1:0]    selWrTarget,
  input logic                busy,
  input logic                memReqValid,
  input logic                memReqWrite,
  input logic [WORD_W-1:0]   memReqWdata,
  input logic                loadDone,
  input logic                loadFault,
  input logic [RIGHTS_W-1:0] curRights,
  input logic [TGT_W-1:0]    shadowSel,
  input logic [BASE_W-1:0]   shadowBase,
  input logic [LIMIT_W-1:0]  shadowLimit,
  input logic [RIGHTS_W-1:0] shadowRights
);
  // R2
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selWrValid && selWrReady && selWrTarget <= TGT_W'(NUM_SEG)) |=> busy);

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  // R9
  mark_sets_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memReqWdata[WORD_W-RIGHTS_W+RB_ACC]);

  // R6
  done_needs_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (curRights[RB_PRESENT] && !loadFault));

  // R5
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> selWrReady);

  // R10
  cache_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadDone |=> (!$stable(shadowSel) ||
                   ($stable(shadowBase) && $stable(shadowLimit) && $stable(shadowRights))));
endmodule

bind seg_shadow_loader seg_shadow_chk #(.NUM_SEG(NUM_SEG)) chk_i (
  .clk(clk), .rstN(rstN), .selWrValid(selWrValid), .selWrReady(selWrReady),
  .selWrTarget(selWrTarget), .busy(busy), .memReqValid(memReqValid),
  .memReqWrite(memReqWrite), .memReqWdata(memReqWdata), .loadDone(loadDone),
  .loadFault(loadFault), .curRights(curRights), .shadowSel(shadowSel),
  .shadowBase(shadowBase), .shadowLimit(shadowLimit), .shadowRights(shadowRights)
);

// File: tb/seg_shadow_loader_tb_top.sv
module seg_shadow_loader_tb_top;
  localparam logic [23:0] GB = 24'h000100;

  logic        clk = 1'b0;
  logic        rstN;
  logic        selWrValid, selWrReady;
  logic [2:0]  selWrTarget;
  logic [15:0] selWrValue;
  logic [23:0] globalBase;
  logic        memReqValid, memReqWrite;
  logic [23:0] memReqAddr;
  logic [15:0] memReqWdata;
  logic        memRspValid;
  logic [15:0] memRspData;
  logic        busy, loadDone, loadFault;
  logic [2:0]  shadowSel;
  logic [23:0] shadowBase;
  logic [15:0] shadowLimit;
  logic [7:0]  shadowRights;

  always #10 clk = ~clk;

  seg_shadow_loader dut_i (
    .clk(clk), .rstN(rstN), .selWrValid(selWrValid), .selWrReady(selWrReady),
    .selWrTarget(selWrTarget), .selWrValue(selWrValue), .globalBase(globalBase),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid), .memRspData(memRspData),
    .busy(busy), .loadDone(loadDone), .loadFault(loadFault), .shadowSel(shadowSel),
    .shadowBase(shadowBase), .shadowLimit(shadowLimit), .shadowRights(shadowRights)
  );

  typedef struct {
    logic [2:0]  tgt;
    logic        flt;
    logic [23:0] base;
    logic [15:0] lim;
    logic [7:0]  rt;
    int          expWr;
    logic        wb;
    logic [7:0]  wbIdx;
    logic [15:0] wbData;
    string       tag;
  } item_t;

  item_t       sbq[$];
  logic [15:0] mem [256];
  logic [23:0] mBase [5];
  logic [15:0] mLim [5];
  logic [7:0]  mRt [5];
  int checks = 0, fails = 0, issued = 0, handled = 0, wrCount = 0, expWrTotal = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putDesc(input int byteAddr, input logic [15:0] lim,
                         input logic [23:0] base, input logic [7:0] rt);
    mem[byteAddr/2]     = lim;
    mem[byteAddr/2 + 1] = base[15:0];
    mem[byteAddr/2 + 2] = {rt, base[23:16]};
  endtask

  // memory responder: one-cycle latency, one response per held request
  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(posedge clk);
      if (memReqValid && !memRspValid) begin
        if (memReqWrite) begin
          mem[memReqAddr[8:1]] = memReqWdata;
          wrCount++;
        end
        memRspData  <= mem[memReqAddr[8:1]];
        memRspValid <= 1'b1;
      end else begin
        memRspValid <= 1'b0;
      end
    end
  end

  // driver: predicts from the requirements, pushes, then drives the write
  task automatic load(input logic [2:0] tgt, input logic [15:0] sel, input string tag);
    item_t it;
    logic [23:0] tb, a;
    logic [15:0] w0, w1, w2;
    logic [7:0]  rt;
    logic [7:0]  wi;
    logic        isData, isStack, flt;
    @(negedge clk);
    while (!selWrReady) @(negedge clk);
    tb = (tgt == 3'd4 || !sel[2]) ? GB : mBase[4];       // R3 R4
    a  = tb + {8'h00, sel[15:3], 3'b000};
    wi = a[8:1];
    w0 = mem[wi];
    w1 = mem[8'(wi + 1)];
    w2 = mem[8'(wi + 2)];
    rt = w2[15:8];
    isData  = (tgt == 3'd1) || (tgt == 3'd3);
    isStack = (tgt == 3'd2);
    flt = !rt[7] || ((isData || isStack) && (sel[1:0] > rt[6:5])) ||   // R6 R7
          (isStack && !(rt[4] && !rt[3] && rt[1]));                     // R8
    it.wb = !flt && rt[4] && !rt[0];                                    // R9
    if (it.wb) expWrTotal++;
    if (!flt) begin
      mBase[tgt] = {w2[7:0], w1};
      mLim[tgt]  = w0;
      mRt[tgt]   = rt | {7'b0, it.wb};
    end
    it.tgt = tgt; it.flt = flt; it.base = mBase[tgt]; it.lim = mLim[tgt];
    it.rt = mRt[tgt]; it.expWr = expWrTotal; it.wbIdx = 8'(wi + 2);
    it.wbData = {rt | 8'h01, w2[7:0]}; it.tag = tag;
    sbq.push_back(it);
    issued++;
    selWrValid  = 1'b1;
    selWrTarget = tgt;
    selWrValue  = sel;
    @(negedge clk);
    selWrValid = 1'b0;
    chk("R2 busy after accept", busy, 1);
    chk("R2 ready low while busy", selWrReady, 0);
    while (handled != issued) @(negedge clk);
  endtask

  // monitor: pops expected items as loads finish
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (loadDone || loadFault) begin
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 unexpected completion actual=1 expected=0");
        end else begin
          it = sbq.pop_front();
          chk({it.tag, " fault flag"}, loadFault, it.flt);
          chk({it.tag, " R5 done flag"}, loadDone, !it.flt);
          @(negedge clk);
          shadowSel = it.tgt;
          #1;
          chk({it.tag, " R5 base"}, shadowBase, it.base);
          chk({it.tag, " R5 limit"}, shadowLimit, it.lim);
          chk({it.tag, " R5 rights"}, shadowRights, it.rt);
          chk({it.tag, " R9 write count"}, wrCount, it.expWr);
          if (it.wb) chk({it.tag, " R9 written word"}, mem[it.wbIdx], it.wbData);
          handled++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; selWrValid = 1'b0; selWrTarget = '0; selWrValue = '0;
    shadowSel = '0; globalBase = GB;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 5; i++) begin mBase[i] = '0; mLim[i] = '0; mRt[i] = '0; end
    // global table at 0x100, local table at 0x180
    putDesc(32'h108, 16'h003F, 24'h000180, 8'h82);   // local-table descriptor
    putDesc(32'h110, 16'hFFFF, 24'h123456, 8'h9A);   // code, accessed clear
    putDesc(32'h118, 16'h0100, 24'h020000, 8'h93);   // data level 0
    putDesc(32'h120, 16'h0200, 24'h060000, 8'h13);   // not present
    putDesc(32'h128, 16'h0300, 24'h070000, 8'h91);   // read-only data
    putDesc(32'h130, 16'h0400, 24'h080000, 8'h9B);   // code
    putDesc(32'h138, 16'h0FFF, 24'h030000, 8'h93);   // writable data
    putDesc(32'h188, 16'h7FFF, 24'h040000, 8'hF3);   // local: data level 3
    putDesc(32'h190, 16'h0010, 24'h050000, 8'hD2);   // local: data level 2
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", selWrReady, 1);
    chk("R1 busy after reset", busy, 0);
    shadowSel = 3'd0; #1;
    chk("R1 entry0 base", shadowBase, 0);
    chk("R1 entry0 rights", shadowRights, 0);
    shadowSel = 3'd4; #1;
    chk("R1 entry4 limit", shadowLimit, 0);

    load(3'd4, 16'h000C, "R4 local table with flag set");
    load(3'd0, 16'h0010, "R9 code with accessed clear");
    load(3'd1, 16'h000F, "R3 data via local table");
    load(3'd3, 16'h001B, "R7 level 3 above level 0");
    load(3'd1, 16'h0020, "R6 not present");
    load(3'd2, 16'h0028, "R8 stack read-only");
    load(3'd2, 16'h0030, "R8 stack code");
    load(3'd2, 16'h0038, "R8 stack writable");
    load(3'd3, 16'h0015, "R7 level 1 below level 2");

    // R10: edit memory without a selector write
    mem[16'h110 / 2] = 16'h1234;
    @(negedge clk);
    shadowSel = 3'd0; #1;
    chk("R10 limit kept after memory edit", shadowLimit, 16'hFFFF);
    repeat (4) @(negedge clk);
    shadowSel = 3'd0; #1;
    chk("R10 limit still kept", shadowLimit, 16'hFFFF);
    load(3'd0, 16'h0010, "R10 reload after write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule